// File: doc/BRIEF.md
# Pipeline Hazard Stall-Forward Unit

This control block sits beside a five-stage in-order pipeline whose stages are fetch, opcode decode, operand fetch, execute and result store. The datapath, the ALU and the register file are not part of it. For each instruction that decode hands over, the unit keeps a small record (valid flag, source registers, destination, and whether it writes, loads or waits on an external access). It moves these records through its own operand-fetch, execute and store slots in step with the datapath.

Each cycle it compares the source registers of the instruction in operand fetch with the destinations of the older instructions in execute and store. It then does one of three things. It selects a bypass path, it holds the front of the pipeline for one cycle when a load result is not ready yet, or it lets the instruction advance. It also holds the pipeline while an external storage or coprocessor access in execute waits for its done strobe. When a branch or call in execute is taken, it discards the younger instructions.

Top module: `hazard_unit`

## Requirements
- R1: A synchronous active-high reset clears all three stage valid bits. While no instruction is valid, `stall`, `flush` and every `fwd_sel` field read 0.
- R2: With no dependency and no stall, an instruction presented with `dec_valid` appears in operand fetch one cycle later, in execute after two cycles and in store after three. Once the pipe has filled, `st_valid` stays high on every cycle.
- R3: `fwd_sel` codes are 0 for the register file, 1 for the execute-stage result and 2 for the store-stage result; field i belongs to source i. When a source of the operand-fetch instruction equals the destination of a valid, writing, non-load instruction in execute, its field reads 1 and no stall is raised.
- R4: When a source matches only the writing instruction in the store stage, its field reads 2. When it matches both execute and store, the execute result (1) wins.
- R5: Register 0 never creates a dependency, and an instruction whose write flag is low never creates one.
- R6: A source that matches the destination of a load in execute raises `stall` for exactly one cycle. A bubble then enters execute (`ex_valid` low), and on the following cycle the field reads 2.
- R7: While the instruction in execute is marked external and `ext_done` is low, `stall` stays high. Operand fetch and execute keep their instructions, and a bubble enters store. In the cycle `ext_done` is high, `stall` is low and the instruction moves on.
- R8: When `branch_taken` is high while execute holds a valid instruction, `flush` is high and the instructions in decode and operand fetch are discarded: next cycle `of_valid` and `ex_valid` are low. The branch itself moves to store.
- R9: Flush takes priority over any stall cause. During a flush `stall` is low and every `fwd_sel` field is 0.
- R10: During a stall the operand-fetch record is held and the decode inputs are ignored. After the stall, the bypass decision is still made for the held instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_src | input | NSRC x REG_W | Source register numbers of the decoded instruction |
| dec_dst | input | REG_W | Destination register number |
| dec_wr | input | 1 | Instruction writes its destination |
| dec_ld | input | 1 | Result only available after execute (load) |
| dec_ext | input | 1 | Instruction performs an external storage or coprocessor access |
| branch_taken | input | 1 | Instruction in execute redirects the flow |
| ext_done | input | 1 | External access of the execute instruction completes |
| stall | output | 1 | Hold fetch, decode and operand fetch |
| flush | output | 1 | Discard fetch, decode and operand-fetch contents |
| fwd_sel | output | NSRC x 2 | Operand source per source: 0 register file, 1 execute, 2 store |
| of_valid | output | 1 | Operand-fetch slot holds an instruction |
| ex_valid | output | 1 | Execute slot holds an instruction |
| st_valid | output | 1 | Store slot holds an instruction (one completes) |

## Verification
The bench targets the load-use case. A unit that forwarded from a load in execute would pass a wrong operand with no stall. One that stalled twice, or let decode overwrite the held instruction, would give the wrong bypass code on the release cycle. It also drives matches in execute and store at the same time, and register-0 and no-write producers, which a faulty comparator would turn into false bypasses. It checks a taken branch that coincides with a load-use hazard or a pending external access: with the priority reversed, `stall` would rise and the wrong-path instruction would survive. Finally it checks an external access whose done strobe arrives at once, where an off-by-one wait loop would insert a spurious stall cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Operand source selection presented to the datapath bypass muxes.
  typedef enum logic [1:0] {
    SRC_RF = 2'd0,
    SRC_EX = 2'd1,
    SRC_ST = 2'd2
  } fwd_src_e;

  localparam int FWD_W = 2;

endpackage

// File: rtl/hz_hit.sv
module hz_hit #(
  parameter int REG_W = 5
) (
  input  logic             prod_v,
  input  logic             prod_wr,
  input  logic [REG_W-1:0] prod_dst,
  input  logic [REG_W-1:0] src,
  output logic             hit
);

  // A producer only creates a dependency when it is live, writes, and
  // targets a register other than the hard-wired zero register.
  assign hit = prod_v && prod_wr && (prod_dst != '0) && (prod_dst == src);

endmodule

// File: rtl/hz_track.sv
module hz_track #(
  parameter int NSRC  = 2,
  parameter int REG_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       ext_wait,
  input  logic                       load_use,
  input  logic                       dec_valid,
  input  logic [NSRC-1:0][REG_W-1:0] dec_src,
  input  logic [REG_W-1:0]           dec_dst,
  input  logic                       dec_wr,
  input  logic                       dec_ld,
  input  logic                       dec_ext,
  output logic                       of_v,
  output logic [NSRC-1:0][REG_W-1:0] of_src,
  output logic                       ex_v,
  output logic [REG_W-1:0]           ex_dst,
  output logic                       ex_wr,
  output logic                       ex_ld,
  output logic                       ex_ext,
  output logic                       st_v,
  output logic [REG_W-1:0]           st_dst,
  output logic                       st_wr
);

  logic [REG_W-1:0] of_dst;
  logic             of_wr, of_ld, of_ext;

  // Valid bits: the only state that needs a reset value.
  always_ff @(posedge clk) begin
    if (rst) begin
      of_v <= 1'b0;
      ex_v <= 1'b0;
      st_v <= 1'b0;
    end else if (flush) begin
      st_v <= ex_v;
      ex_v <= 1'b0;
      of_v <= 1'b0;
    end else if (ext_wait) begin
      st_v <= 1'b0;
    end else if (load_use) begin
      st_v <= ex_v;
      ex_v <= 1'b0;
    end else begin
      st_v <= ex_v;
      ex_v <= of_v;
      of_v <= dec_valid;
    end
  end

  // Payload fields: no reset, loaded only when their slot moves.
  always_ff @(posedge clk) begin
    if (!ext_wait || flush) begin
      st_dst <= ex_dst;
      st_wr  <= ex_wr;
    end
    if (!flush && !ext_wait && !load_use) begin
      ex_dst <= of_dst;
      ex_wr  <= of_wr;
      ex_ld  <= of_ld;
      ex_ext <= of_ext;
      of_src <= dec_src;
      of_dst <= dec_dst;
      of_wr  <= dec_wr;
      of_ld  <= dec_ld;
      of_ext <= dec_ext;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!of_v && !ex_v && !st_v));

  // R8
  flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!of_v && !ex_v));

  // R7
  ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_wait && !flush) |=> (ex_v && !st_v));

  // R6
  load_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (load_use && !flush && !ext_wait) |=> (!ex_v && of_v));

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int NSRC  = 2,
  parameter int REG_W = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               dec_valid,
  input  logic [NSRC-1:0][REG_W-1:0]         dec_src,
  input  logic [REG_W-1:0]                   dec_dst,
  input  logic                               dec_wr,
  input  logic                               dec_ld,
  input  logic                               dec_ext,
  input  logic                               branch_taken,
  input  logic                               ext_done,
  output logic                               stall,
  output logic                               flush,
  output logic [NSRC-1:0][hz_pkg::FWD_W-1:0] fwd_sel,
  output logic                               of_valid,
  output logic                               ex_valid,
  output logic                               st_valid
);

  import hz_pkg::*;

  logic [NSRC-1:0][REG_W-1:0] of_src;
  logic [REG_W-1:0]           ex_dst, st_dst;
  logic                       ex_wr, ex_ld, ex_ext, st_wr;
  logic [NSRC-1:0]            ex_hit, st_hit;
  logic                       ext_wait, load_use;

  hz_track #(.NSRC(NSRC), .REG_W(REG_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .ext_wait  (ext_wait),
    .load_use  (load_use),
    .dec_valid (dec_valid),
    .dec_src   (dec_src),
    .dec_dst   (dec_dst),
    .dec_wr    (dec_wr),
    .dec_ld    (dec_ld),
    .dec_ext   (dec_ext),
    .of_v      (of_valid),
    .of_src    (of_src),
    .ex_v      (ex_valid),
    .ex_dst    (ex_dst),
    .ex_wr     (ex_wr),
    .ex_ld     (ex_ld),
    .ex_ext    (ex_ext),
    .st_v      (st_valid),
    .st_dst    (st_dst),
    .st_wr     (st_wr)
  );

  // One comparator pair per source operand.
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    hz_hit #(.REG_W(REG_W)) u_ex_hit (
      .prod_v   (ex_valid),
      .prod_wr  (ex_wr),
      .prod_dst (ex_dst),
      .src      (of_src[i]),
      .hit      (ex_hit[i])
    );
    hz_hit #(.REG_W(REG_W)) u_st_hit (
      .prod_v   (st_valid),
      .prod_wr  (st_wr),
      .prod_dst (st_dst),
      .src      (of_src[i]),
      .hit      (st_hit[i])
    );

    always_comb begin
      if (!of_valid || stall || flush) fwd_sel[i] = SRC_RF;
      else if (ex_hit[i])              fwd_sel[i] = SRC_EX;
      else if (st_hit[i])              fwd_sel[i] = SRC_ST;
      else                             fwd_sel[i] = SRC_RF;
    end

    // R3
    ex_fwd_src_chk: assert property (@(posedge clk) disable iff (rst)
      (fwd_sel[i] == SRC_EX) |-> (ex_valid && !ex_ld && !stall));

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (rst)
      (of_src[i] == '0) |-> (fwd_sel[i] == SRC_RF));
  end

  // Priority: flush, then external wait, then load-use bubble.
  assign flush    = ex_valid && branch_taken;
  assign ext_wait = ex_valid && ex_ext && !ext_done;
  assign load_use = of_valid && ex_ld && (|ex_hit);
  assign stall    = !flush && (ext_wait || load_use);

endmodule

// File: tb/hazard_unit_test.sv
module hazard_unit_test;

  localparam int NSRC  = 2;
  localparam int REG_W = 5;
  localparam int NV    = 22;

  typedef struct packed {
    logic             dv;
    logic [REG_W-1:0] sa, sb, dst;
    logic             wr, ld, ext, br, done;
    logic             e_stall, e_flush;
    logic [1:0]       e_fa, e_fb;
    logic             e_of, e_ex, e_st;
  } vec_t;

  // Columns: dv sa sb dst wr ld ext br done | stall flush fa fb of ex st
  localparam vec_t VECS [NV] = '{
    '{1, 1, 2, 3,1,0,0,0,0, 0,0,0,0,0,0,0},  // fill (R2)
    '{1, 3, 4, 5,1,0,0,0,0, 0,0,0,0,1,0,0},
    '{1, 5, 3, 6,1,0,0,0,0, 0,0,1,0,1,1,0},  // R3 a<-EX
    '{1, 0, 0, 0,1,0,0,0,0, 0,0,1,2,1,1,1},  // R3 a<-EX, R4 b<-ST
    '{1, 0, 6, 7,0,0,0,0,0, 0,0,0,0,1,1,1},  // R5 src 0
    '{1, 7, 0, 8,1,0,0,0,0, 0,0,0,2,1,1,1},  // R5 dst0 in EX skipped, b<-ST
    '{1, 1, 0, 9,1,1,0,0,0, 0,0,0,0,1,1,1},  // R5 no-write producer
    '{1, 9, 9,10,1,0,0,0,0, 0,0,0,0,1,1,1},
    '{1, 2, 2,11,1,0,0,0,0, 1,0,0,0,1,1,1},  // R6 load-use stall
    '{1, 2, 2,11,1,0,0,0,0, 0,0,2,2,1,0,1},  // R6 bubble, R10 held op
    '{1, 0, 0, 0,0,0,1,0,0, 0,0,0,0,1,1,0},
    '{1,12,13,14,1,0,0,0,0, 0,0,0,0,1,1,1},
    '{1,14, 0, 0,0,0,0,0,0, 1,0,0,0,1,1,1},  // R7 ext wait
    '{1,14, 0, 0,0,0,0,0,0, 1,0,0,0,1,1,0},  // R7 bubble in store
    '{1,14, 0, 0,0,0,0,0,1, 0,0,0,0,1,1,0},  // R7 done releases
    '{1, 0, 0,16,1,1,0,0,0, 0,0,1,0,1,1,1},
    '{1,16, 0,17,1,0,0,1,0, 0,1,0,0,1,1,1},  // R8 flush
    '{1, 0, 0,20,1,1,0,0,0, 0,0,0,0,0,0,1},  // R8 younger dropped
    '{1,20,20,21,1,0,0,0,0, 0,0,0,0,1,0,0},
    '{1, 1, 1, 2,1,0,0,1,0, 0,1,0,0,1,1,0},  // R9 flush beats load-use
    '{0, 0, 0, 0,0,0,0,0,0, 0,0,0,0,0,0,1},
    '{0, 0, 0, 0,0,0,0,0,0, 0,0,0,0,0,0,0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_valid = 1'b0;
  logic [NSRC-1:0][REG_W-1:0] dec_src = '0;
  logic [REG_W-1:0] dec_dst = '0;
  logic dec_wr = 1'b0, dec_ld = 1'b0, dec_ext = 1'b0;
  logic branch_taken = 1'b0, ext_done = 1'b0;
  logic stall, flush, of_valid, ex_valid, st_valid;
  logic [NSRC-1:0][1:0] fwd_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hazard_unit #(.NSRC(NSRC), .REG_W(REG_W)) uut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_src(dec_src),
    .dec_dst(dec_dst), .dec_wr(dec_wr), .dec_ld(dec_ld), .dec_ext(dec_ext),
    .branch_taken(branch_taken), .ext_done(ext_done), .stall(stall),
    .flush(flush), .fwd_sel(fwd_sel), .of_valid(of_valid),
    .ex_valid(ex_valid), .st_valid(st_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic dv, input int sa, input int sb, input int dst,
                       input logic wr, input logic ld, input logic ext,
                       input logic br, input logic done);
    @(negedge clk);
    dec_valid = dv;
    dec_src = {REG_W'(sb), REG_W'(sa)};
    dec_dst = REG_W'(dst);
    dec_wr = wr; dec_ld = ld; dec_ext = ext;
    branch_taken = br; ext_done = done;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 state after reset
    chk("R1 of_valid", of_valid, 0);
    chk("R1 ex_valid", ex_valid, 0);
    chk("R1 st_valid", st_valid, 0);
    chk("R1 stall", stall, 0);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].dv, VECS[k].sa, VECS[k].sb, VECS[k].dst, VECS[k].wr,
            VECS[k].ld, VECS[k].ext, VECS[k].br, VECS[k].done);
      chk($sformatf("R6 R7 R9 stall row%0d", k), stall, VECS[k].e_stall);
      chk($sformatf("R8 R9 flush row%0d", k), flush, VECS[k].e_flush);
      chk($sformatf("R3 R4 R5 R10 fwd_a row%0d", k), fwd_sel[0], VECS[k].e_fa);
      chk($sformatf("R3 R4 R5 R10 fwd_b row%0d", k), fwd_sel[1], VECS[k].e_fb);
      chk($sformatf("R2 R8 of_valid row%0d", k), of_valid, VECS[k].e_of);
      chk($sformatf("R2 R6 ex_valid row%0d", k), ex_valid, VECS[k].e_ex);
      chk($sformatf("R2 R7 st_valid row%0d", k), st_valid, VECS[k].e_st);
    end

    // R7 done already high when the external access reaches execute
    drive(1, 0, 0, 0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7 no stall on early done", stall, 0);
    chk("R7 ext in execute", ex_valid, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 ext moved to store", st_valid, 1);
    chk("R7 execute empty", ex_valid, 0);

    // R9 taken branch while an external access is pending
    drive(1, 0, 0, 0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R9 flush over ext wait", flush, 1);
    chk("R9 stall low in flush", stall, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 branch reached store", st_valid, 1);

    // R2 steady throughput with independent instructions
    for (int k = 0; k < 10; k++) begin
      drive(1, 0, 0, k + 1, 1, 0, 0, 0, 0);
      if (k >= 3) begin
        chk($sformatf("R2 completion cycle%0d", k), st_valid, 1);
        chk($sformatf("R2 no stall cycle%0d", k), stall, 0);
      end
    end

    // R1 reset with a full pipeline
    @(negedge clk);
    rst = 1'b1;
    dec_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 mid-run of_valid", of_valid, 0);
    chk("R1 mid-run ex_valid", ex_valid, 0);
    chk("R1 mid-run st_valid", st_valid, 0);
    chk("R1 mid-run flush", flush, 0);
    chk("R1 mid-run fwd_a", fwd_sel[0], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule